// File: doc/BRIEF.md
# Serial SRAM Command and Addressing Sequencer

This block is the transaction engine behind a serial static-RAM port. A serial front end, which handles pins, bus width and bit timing, delivers every complete byte it receives as a one-cycle strobe. Whenever it needs a byte to shift out, it raises a one-cycle request. The sequencer takes the first byte of each chip-select window as an instruction and collects the three address bytes that follow. It then streams data between the front end and a synchronous byte-wide array.

A two-bit mode register sets the address policy used during data phases. In single-byte mode only one data byte is moved. In page mode the address wraps inside an aligned 32-byte page. In sequential mode the address runs across the whole array and wraps from the last location back to zero. Two further instructions read and write the mode register. Deasserting the select input ends any transaction in any state, and the next select window starts again at the instruction byte.

Top module: `sqs_sequencer`

## Requirements
- R1: While selected, the first received byte is decoded as follows: 0x03 starts a read, 0x02 a write, 0x05 a mode-register read and 0x01 a mode-register write. Any other value makes the block ignore every later byte and request until select drops, with no array write.
- R2: After a read or write instruction, three address bytes are taken most significant first. Only the low 17 bits of the 24-bit field form the array address; the top 7 bits have no effect.
- R3: In a read data phase, each request produces `tx_valid` for one cycle, two clock edges later. `tx_byte` then carries the array byte at the current address, and the address advances after each request.
- R4: In a write data phase, each received byte raises `mem_we` for exactly one cycle, starting at the edge after the byte strobe, with the current address and that byte. The address then advances. `mem_we` is never high unless a byte strobe came one cycle before.
- R5: Mode bits [7:6] encode 00 single-byte, 10 page and 01 sequential. After reset the mode is sequential and no output strobe is active.
- R6: A mode-register read answers each request, two edges later, with the mode in bits [7:6] and zero in bits [5:0].
- R7: A mode-register write whose bits [7:6] are 11 leaves the previous mode in place. Any other value takes effect for the following transactions.
- R8: In single-byte mode only the first data byte of a transaction reaches the array. Later reads return filler 0x00, and later writes cause no array write.
- R9: In page mode the address goes from offset 31 of a page to offset 0 of the same page. Address bits above bit 4 never change within a transaction.
- R10: In sequential mode the address increments by one across page boundaries and rolls over from 0x1FFFF to 0x00000.
- R11: Deasserting select at any point, including in the middle of the address bytes, abandons the transaction. The next select window is decoded from its first byte as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | High for the duration of a transaction |
| rx_valid | input | 1 | One-cycle strobe: a complete byte arrived |
| rx_byte | input | 8 | Byte that arrived with `rx_valid` |
| tx_req | input | 1 | One-cycle request for the next outgoing byte |
| tx_valid | output | 1 | Outgoing byte is ready, two edges after `tx_req` |
| tx_byte | output | 8 | Outgoing byte, valid with `tx_valid` |
| mem_addr | output | ADDR_W | Array address |
| mem_we | output | 1 | Array write enable |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, one edge after `mem_addr` |

## Verification
The checker assumes that `rx_valid` and `tx_req` are single-cycle pulses that never arrive in the same cycle. It also assumes that both are seen only while `sel_i` is high, and that the array returns read data on the edge after it receives an address. The bench drives every byte and request from its tasks at the falling edge, separated by idle cycles. It holds select across whole transactions and models the array with exactly that one-edge read latency, so all stimulus stays within these assumptions. Random transactions mix the three modes, start addresses near page and array ends, random upper address bits and lengths up to 36 bytes.

// File: rtl/sqs_pkg.sv
package sqs_pkg;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_RDMODE = 8'h05;
  localparam logic [7:0] OP_WRMODE = 8'h01;

  typedef enum logic [1:0] {
    MD_BYTE = 2'b00,
    MD_SEQ  = 2'b01,
    MD_PAGE = 2'b10,
    MD_RSVD = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_RD, ST_WR, ST_MRD, ST_MWR, ST_HALT
  } st_e;

  typedef enum logic [1:0] {
    TX_FILL, TX_MEM, TX_MODE
  } txsrc_e;

  // Next address under a mode; aw = array address bits, pw = page offset bits.
  function automatic logic [23:0] adv_addr(input logic [23:0] a, input mode_e m,
                                           input int unsigned aw, input int unsigned pw);
    logic [23:0] amask;
    logic [23:0] pmask;
    amask = (24'd1 << aw) - 24'd1;
    pmask = (24'd1 << pw) - 24'd1;
    case (m)
      MD_PAGE: adv_addr = (a & ~pmask) | ((a + 24'd1) & pmask);
      MD_SEQ:  adv_addr = (a + 24'd1) & amask;
      default: adv_addr = a;
    endcase
  endfunction
endpackage

// File: rtl/sqs_mode_reg.sv
module sqs_mode_reg
  import sqs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_field,
  output mode_e      mode_o
);
  mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_SEQ;
    end else if (wr_en && (wr_field != 2'b11)) begin
      mode_q <= mode_e'(wr_field);
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/sqs_addr_unit.sv
module sqs_addr_unit
  import sqs_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [7:0]        shift_byte,
  input  logic              step_en,
  input  mode_e             mode,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (shift_en) begin
      ptr_q <= ADDR_W'({ptr_q, shift_byte});
    end else if (step_en) begin
      ptr_q <= ADDR_W'(adv_addr(24'(ptr_q), mode, ADDR_W, PAGE_W));
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/sqs_sequencer.sv
module sqs_sequencer
  import sqs_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PAGE_W     = 5,
  parameter int ADDR_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_req,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int ACNT_W = $clog2(ADDR_BYTES + 1);

  st_e               st_q, st_d;
  logic [ACNT_W-1:0] acnt_q, acnt_d;
  logic              rd_op_q;
  mode_e             mode_w;
  logic [ADDR_W-1:0] ptr_w;
  logic              single;

  // named events
  logic cmd_fire, addr_fire, wr_fire, rd_fire, mrd_fire, mwr_fire, acc_fire, addr_last;

  assign single    = (mode_w == MD_BYTE);
  assign cmd_fire  = sel_i && rx_valid && (st_q == ST_CMD);
  assign addr_fire = sel_i && rx_valid && (st_q == ST_ADDR);
  assign wr_fire   = sel_i && rx_valid && (st_q == ST_WR);
  assign rd_fire   = sel_i && tx_req   && (st_q == ST_RD);
  assign mrd_fire  = sel_i && tx_req   && (st_q == ST_MRD);
  assign mwr_fire  = sel_i && rx_valid && (st_q == ST_MWR);
  assign acc_fire  = wr_fire || rd_fire;
  assign addr_last = addr_fire && (acnt_q == ACNT_W'(ADDR_BYTES - 1));

  sqs_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (mwr_fire),
    .wr_field (rx_byte[7:6]),
    .mode_o   (mode_w)
  );

  sqs_addr_unit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (addr_fire),
    .shift_byte (rx_byte),
    .step_en    (acc_fire),
    .mode       (mode_w),
    .ptr_o      (ptr_w)
  );

  always_comb begin
    st_d   = st_q;
    acnt_d = acnt_q;
    if (!sel_i) begin
      st_d   = ST_CMD;
      acnt_d = '0;
    end else begin
      case (st_q)
        ST_CMD: if (rx_valid) begin
          case (rx_byte)
            OP_READ, OP_WRITE: st_d = ST_ADDR;
            OP_RDMODE:         st_d = ST_MRD;
            OP_WRMODE:         st_d = ST_MWR;
            default:           st_d = ST_HALT;
          endcase
        end
        ST_ADDR: if (rx_valid) begin
          acnt_d = acnt_q + 1'b1;
          if (addr_last) st_d = rd_op_q ? ST_RD : ST_WR;
        end
        ST_RD:   if (tx_req && single)   st_d = ST_HALT;
        ST_WR:   if (rx_valid && single) st_d = ST_HALT;
        ST_MWR:  if (rx_valid)           st_d = ST_HALT;
        default: st_d = st_q;
      endcase
    end
  end

  txsrc_e src1_q, src2_q;
  logic   req1_q, txv_q;
  logic   we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_CMD;
      acnt_q  <= '0;
      rd_op_q <= 1'b0;
      req1_q  <= 1'b0;
      txv_q   <= 1'b0;
      src1_q  <= TX_FILL;
      src2_q  <= TX_FILL;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q   <= st_d;
      acnt_q <= acnt_d;
      if (cmd_fire) rd_op_q <= (rx_byte == OP_READ);
      req1_q <= sel_i && tx_req;
      txv_q  <= req1_q;
      src1_q <= rd_fire ? TX_MEM : (mrd_fire ? TX_MODE : TX_FILL);
      src2_q <= src1_q;
      we_q   <= wr_fire;
      if (acc_fire) addr_q  <= ptr_w;
      if (wr_fire)  wdata_q <= rx_byte;
    end
  end

  always_comb begin
    case (src2_q)
      TX_MEM:  tx_byte = mem_rdata;
      TX_MODE: tx_byte = {mode_w, 6'b000000};
      default: tx_byte = 8'h00;
    endcase
  end

  assign tx_valid  = txv_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/sqs_sequencer_chk.sv
module sqs_sequencer_chk #(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic              rx_valid,
  input logic              tx_req,
  input logic              tx_valid,
  input logic              mem_we,
  input logic [1:0]        mode,
  input logic              acc_fire,
  input logic [ADDR_W-1:0] acc_addr
);
  logic [ADDR_W-1:0] last_q;
  logic              have_q;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!sel_i) begin
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (acc_fire) begin
      last_q <= acc_addr;
      have_q <= 1'b1;
      if (cnt_q != 2'b11) cnt_q <= cnt_q + 2'b01;
    end
  end

  AST_WE_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(rx_valid)); // R4
  AST_TXV_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_req, 2)); // R3
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11); // R7
  AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && mode == 2'b00) |-> (cnt_q == 2'b00)); // R8
  AST_PAGE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && have_q && mode == 2'b10) |->
      (acc_addr[ADDR_W-1:PAGE_W] == last_q[ADDR_W-1:PAGE_W])); // R9
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && have_q && mode == 2'b01) |-> (acc_addr == ADDR_W'(last_q + 1'b1))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !mem_we); // R11
endmodule

bind sqs_sequencer sqs_sequencer_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_i    (sel_i),
  .rx_valid (rx_valid),
  .tx_req   (tx_req),
  .tx_valid (tx_valid),
  .mem_we   (mem_we),
  .mode     (mode_w),
  .acc_fire (acc_fire),
  .acc_addr (ptr_w)
);

// File: tb/tb_sqs_sequencer.sv
module tb_sqs_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ASPACE = 131072;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_i = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic tx_req = 1'b0;
  logic tx_valid;
  logic [7:0] tx_byte;
  logic [16:0] mem_addr;
  logic mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  int ref_md = 1;
  bit done = 1'b0;
  logic [7:0] arr [int];
  logic [7:0] ref_mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  sqs_sequencer dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    mem_rdata <= arr.exists(int'(mem_addr)) ? arr[int'(mem_addr)] : 8'h00;
    if (mem_we) begin
      arr[int'(mem_addr)] = mem_wdata;
      we_cnt = we_cnt + 1;
    end
  end

  function automatic int nxt(input int a, input int md);
    if (md == 2) return (a / 32) * 32 + ((a % 32) + 1) % 32;
    if (md == 1) return (a + 1) % ASPACE;
    return a;
  endfunction

  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_t();
    @(negedge clk); sel_i = 1'b1;
  endtask

  task automatic stop_t();
    @(negedge clk); sel_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic get_byte(output logic v, output logic [7:0] b);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    @(negedge clk); v = tx_valid; b = tx_byte;
  endtask

  task automatic send_addr(input logic [7:0] op, input logic [23:0] f);
    send_byte(op); send_byte(f[23:16]); send_byte(f[15:8]); send_byte(f[7:0]);
  endtask

  task automatic wr_txn(input logic [23:0] f, input int n);
    int a;
    int w0;
    int expw;
    logic [7:0] d;
    a = int'(f & 24'h01FFFF);
    w0 = we_cnt;
    expw = 0;
    start_t();
    send_addr(8'h02, f);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d);
      if (!(ref_md == 0 && i > 0)) begin
        ref_mem[a] = d;
        expw++;
        a = nxt(a, ref_md);
      end
    end
    stop_t();
    chk(we_cnt - w0 == expw, (ref_md == 0) ? "R8 write count" : "R4 write count",
        we_cnt - w0, expw);
  endtask

  task automatic rd_txn(input logic [23:0] f, input int n, input string tag);
    int a;
    logic v;
    logic [7:0] b;
    logic [7:0] e;
    a = int'(f & 24'h01FFFF);
    start_t();
    send_addr(8'h03, f);
    for (int i = 0; i < n; i++) begin
      get_byte(v, b);
      e = (ref_md == 0 && i > 0) ? 8'h00 : ref_rd(a);
      chk(v == 1'b1, "R3 tx_valid", int'(v), 1);
      chk(b == e, tag, int'(b), int'(e));
      a = nxt(a, ref_md);
    end
    stop_t();
  endtask

  task automatic set_mode(input logic [7:0] b);
    start_t(); send_byte(8'h01); send_byte(b); stop_t();
    if (b[7:6] != 2'b11) ref_md = int'(b[7:6]);
  endtask

  task automatic chk_mode(input string tag);
    logic v;
    logic [7:0] b;
    start_t(); send_byte(8'h05); get_byte(v, b); stop_t();
    chk(v == 1'b1 && b == {2'(ref_md), 6'b0}, tag, int'(b), ref_md * 64);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0;
    logic v;
    logic [7:0] b;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    // R5 reset state
    chk(tx_valid == 1'b0 && mem_we == 1'b0, "R5 reset strobes", int'({tx_valid, mem_we}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_mode("R5 reset mode sequential");

    // R10 rollover in sequential mode
    wr_txn(24'h01FFFE, 4);
    rd_txn(24'h01FFFE, 4, "R10 rollover");
    rd_txn(24'h000000, 2, "R10 wrapped data");

    // R2 upper seven bits ignored
    wr_txn(24'hFE0100, 1);
    rd_txn(24'h000100, 1, "R2 upper bits");

    // R9 page wrap
    set_mode(8'h80);
    chk_mode("R6 page readback");
    wr_txn(24'h00A3DC, 40);
    rd_txn(24'h00A3DC, 34, "R9 page wrap");
    rd_txn(24'h00A3E0, 1, "R9 next page untouched");

    // R8 byte mode
    set_mode(8'h00);
    wr_txn(24'h002000, 3);
    rd_txn(24'h002000, 3, "R8 single byte");
    set_mode(8'h40);
    rd_txn(24'h002000, 3, "R8 extra writes ignored");

    // R7 reserved mode keeps previous; R6 reserved bits read zero
    set_mode(8'h00);
    set_mode(8'hC0);
    chk_mode("R7 reserved ignored");
    set_mode(8'h7F);
    chk_mode("R6 reserved bits zero");

    // R1 unknown instruction
    w0 = we_cnt;
    start_t();
    send_byte(8'h9A); send_byte(8'h02); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'h50); send_byte(8'hAA); send_byte(8'h55);
    get_byte(v, b);
    chk(b == 8'h00, "R1 unknown filler", int'(b), 0);
    stop_t();
    chk(we_cnt == w0, "R1 unknown no write", we_cnt - w0, 0);
    rd_txn(24'h000050, 2, "R1 data untouched");

    // R11 abort mid-address
    w0 = we_cnt;
    start_t(); send_byte(8'h02); send_byte(8'h00); send_byte(8'h00); stop_t();
    start_t(); send_byte(8'h05); get_byte(v, b); stop_t();
    chk(b == {2'(ref_md), 6'b0}, "R11 fresh instruction", int'(b), ref_md * 64);
    chk(we_cnt == w0, "R11 no write", we_cnt - w0, 0);
    wr_txn(24'h000050, 2);
    rd_txn(24'h000050, 2, "R11 after abort");

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [23:0] f;
      int n;
      int sel;
      if ($urandom % 4 == 0) begin
        sel = int'($urandom % 3);
        set_mode(8'(sel) << 6);
      end
      sel = int'($urandom % 3);
      f[23:17] = 7'($urandom);
      if (sel == 0) f[16:0] = 17'($urandom % 64);
      else if (sel == 1) f[16:0] = 17'(ASPACE - 1 - int'($urandom % 40));
      else f[16:0] = {12'($urandom), 5'd24 + 5'($urandom % 8)};
      n = 1 + int'($urandom % 36);
      if ($urandom % 2 == 0) wr_txn(f, n);
      else rd_txn(f, n, (ref_md == 2) ? "R9 random" : (ref_md == 1) ? "R10 random" : "R8 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule